// File: doc/BRIEF.md
# Receive Symbol Aligner and Decoder

This block sits on the receive side of a 100 Mb/s physical layer, between the symbol clock domain and the MII. Each cycle it takes one 5-bit group from the line. The group boundaries need not match the code-group boundaries. The block removes the stream cipher and finds the true symbol boundaries by looking for the start-of-stream pair. It then decodes 4B/5B code groups into MII nibbles with data-valid and error flags.

The descrambler gains lock by itself from the inter-frame idle fill. The plaintext of an idle is all ones, so the complement of the received bits is the keystream. A shadow register holds those complemented bits. A run of idle-consistent symbols copies the shadow into the working keystream register. A run of idles must pass between frames for this to happen. Alignment is taken from the start pair only; any other pattern after idle is ignored. A frame ends on the end delimiter, on two idles, or at once on link failure. A `receiving` flag shows that a frame is in progress, for use by carrier and collision logic.

Top module: `rx_sym_decoder`

## Requirements
- R1: `lock_ok` rises only after LOCK_IDLES (13) consecutive symbols that are consistent with idle fill. No frame may start while `lock_ok` is low.
- R2: The keystream comes from an 11-bit LFSR, x^11+x^9+1, stepped once per bit. The new bit is s[10]^s[8] and is shifted in at bit 0. Descrambled bit = received bit XOR new bit. Within `sym_in`, bit 4 is first in time. When `cipher_bypass` is 1, the XOR is skipped and the lock condition becomes a raw 11111 group.
- R3: The start pair J (11000) then K (10001) is found in the descrambled bit stream at any of the five bit offsets against the incoming 5-bit groups. That offset is then used for every symbol of the frame.
- R4: A frame starts with two nibbles of value 0101, one for J and one for K. `rx_dv` rises with the first of them.
- R5: Inside a frame, each data code group gives its 4-bit value with `rx_er` low. The code groups are: 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R6: Inside a frame, any group that is not data, idle (11111) or T (01101) — this includes H (00100), J, K, R and unused codes such as 00000 — gives a nibble with `rx_er`=1, `rxd`=0000 and `rx_dv`=1.
- R7: The T symbol ends the frame. `rx_dv` is low from the T symbol's slot onward, so the frame holds exactly J, K and the data nibbles.
- R8: A single idle inside a frame is reported as one error nibble (`rx_er`=1, `rxd`=0000). A second consecutive idle ends the frame before any T.
- R9: `link_fail` high at a clock edge drops `rx_dv` and `lock_ok` at that edge.
- R10: A J that is not followed by K after idle fill (J then data 0) starts no frame.
- R11: `receiving` is high exactly in the cycles in which `rx_dv` is high.
- R12: After reset, `rxd`=0000, and `rx_dv`, `rx_er`, `receiving` and `lock_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive symbol clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_in | input | 5 | Unaligned line bits, bit 4 first in time |
| cipher_bypass | input | 1 | 1 = stream carries no cipher |
| link_fail | input | 1 | Link failure; aborts reception and lock |
| rxd | output | 4 | Decoded nibble |
| rx_dv | output | 1 | Nibble belongs to a frame |
| rx_er | output | 1 | Nibble came from an invalid code group |
| receiving | output | 1 | Frame in progress |
| lock_ok | output | 1 | Descrambler has locked to idle fill |

## Verification
The main path is driven by a bench-side transmit model that scrambles a bit stream and then cuts it into 5-bit groups. The sweep covers both cipher settings against all five bit slips, and each payload carries every nibble value once. This separates a wrong offset choice, a wrong bit order and a wrong keystream from one another. Error, idle-abort and link-failure frames show whether the decoder tells H and unused codes apart from T and idle. A J followed by data, and an idle run one symbol short of the lock count, show that the start check and the lock counter are strict rather than greedy.

// File: rtl/rx_sym_pkg.sv
package rx_sym_pkg;
   localparam int SYM_W = 5;
   localparam int NIB_W = 4;

   localparam logic [SYM_W-1:0] C_J    = 5'b11000;
   localparam logic [SYM_W-1:0] C_K    = 5'b10001;
   localparam logic [SYM_W-1:0] C_T    = 5'b01101;
   localparam logic [SYM_W-1:0] C_IDLE = 5'b11111;
   localparam logic [NIB_W-1:0] SSD_NIB = 4'h5;

   typedef enum logic [1:0] {SK_DATA, SK_IDLE, SK_END, SK_BAD} sym_kind_e;

   typedef struct packed {
      sym_kind_e        kind;
      logic [NIB_W-1:0] nib;
   } sym_dec_t;

   typedef enum logic [1:0] {FS_HUNT, FS_SSD2, FS_BODY} frame_st_e;

   function automatic sym_dec_t decode_sym(input logic [SYM_W-1:0] c);
      sym_dec_t r;
      r.kind = SK_DATA;
      r.nib  = '0;
      case (c)
         5'b11110: r.nib = 4'h0;
         5'b01001: r.nib = 4'h1;
         5'b10100: r.nib = 4'h2;
         5'b10101: r.nib = 4'h3;
         5'b01010: r.nib = 4'h4;
         5'b01011: r.nib = 4'h5;
         5'b01110: r.nib = 4'h6;
         5'b01111: r.nib = 4'h7;
         5'b10010: r.nib = 4'h8;
         5'b10011: r.nib = 4'h9;
         5'b10110: r.nib = 4'hA;
         5'b10111: r.nib = 4'hB;
         5'b11010: r.nib = 4'hC;
         5'b11011: r.nib = 4'hD;
         5'b11100: r.nib = 4'hE;
         5'b11101: r.nib = 4'hF;
         C_IDLE:   r.kind = SK_IDLE;
         C_T:      r.kind = SK_END;
         default:  r.kind = SK_BAD;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/rx_sym_descram.sv
module rx_sym_descram
   import rx_sym_pkg::*;
#(
   parameter int LFSR_W     = 11,
   parameter int LFSR_TAP   = 9,
   parameter int LOCK_IDLES = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] sym_in,
   input  logic             bypass,
   input  logic             link_fail,
   output logic [SYM_W-1:0] plain,
   output logic             locked
);
   localparam int CNT_W = $clog2(LOCK_IDLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_IDLES - 1);

   // keystream bits for one symbol, first bit in the MSB
   function automatic logic [SYM_W-1:0] key_bits(input logic [LFSR_W-1:0] s);
      logic [LFSR_W-1:0] t;
      logic [SYM_W-1:0]  k;
      t = s;
      for (int i = SYM_W - 1; i >= 0; i--) begin
         k[i] = t[LFSR_W-1] ^ t[LFSR_TAP-1];
         t    = {t[LFSR_W-2:0], k[i]};
      end
      return k;
   endfunction

   function automatic logic [LFSR_W-1:0] key_next(input logic [LFSR_W-1:0] s);
      logic [LFSR_W-1:0] t;
      t = s;
      for (int i = 0; i < SYM_W; i++) begin
         t = {t[LFSR_W-2:0], t[LFSR_W-1] ^ t[LFSR_TAP-1]};
      end
      return t;
   endfunction

   logic [SYM_W-1:0]  sym_q;
   logic [LFSR_W-1:0] ks_q, sh_q, sh_nx;
   logic [CNT_W-1:0]  cnt_q;
   logic              match, reload;

   // idle plaintext is all ones, so the complement of the line is keystream
   assign sh_nx  = {sh_q[LFSR_W-SYM_W-1:0], ~sym_q};
   assign match  = bypass ? (&sym_q) : (key_bits(sh_q) == ~sym_q);
   assign reload = match && (cnt_q == CNT_LAST);
   assign plain  = bypass ? sym_q : (sym_q ^ key_bits(ks_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_q  <= '0;
         sh_q   <= '0;
         ks_q   <= '0;
         cnt_q  <= '0;
         locked <= 1'b0;
      end else begin
         sym_q <= sym_in;
         sh_q  <= sh_nx;
         ks_q  <= reload ? sh_nx : key_next(ks_q);
         if (link_fail) begin
            cnt_q  <= '0;
            locked <= 1'b0;
         end else if (!match) begin
            cnt_q <= '0;
         end else if (reload) begin
            cnt_q  <= '0;
            locked <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rx_sym_aligner.sv
module rx_sym_aligner
   import rx_sym_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] plain,
   input  logic             hold,
   output logic             jk_hit,
   output logic [SYM_W-1:0] aligned
);
   localparam int OFF_W = $clog2(SYM_W);
   localparam int WIN_W = 3 * SYM_W;
   localparam int OLD_W = 2 * SYM_W;

   logic [SYM_W-1:0] d1_q, d2_q;
   logic [WIN_W-1:0] win;
   logic [OLD_W-1:0] old_pair;
   logic [SYM_W-1:0] hit;
   logic [OFF_W-1:0] hit_off, off_q;

   assign win      = {d2_q, d1_q, plain};
   assign old_pair = {d2_q, d1_q};

   // J in the oldest slot at offset o, K right behind it
   for (genvar o = 0; o < SYM_W; o++) begin : g_scan
      assign hit[o] = (win[WIN_W-1-o -: SYM_W] == C_J) &&
                      (win[WIN_W-1-SYM_W-o -: SYM_W] == C_K);
   end

   assign jk_hit = |hit;

   always_comb begin
      hit_off = '0;
      for (int o = SYM_W - 1; o >= 0; o--) begin
         if (hit[o]) hit_off = OFF_W'(o);
      end
   end

   always_comb begin
      aligned = '0;
      for (int o = 0; o < SYM_W; o++) begin
         if (off_q == OFF_W'(o)) aligned = old_pair[OLD_W-1-o -: SYM_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d1_q  <= '0;
         d2_q  <= '0;
         off_q <= '0;
      end else begin
         d1_q <= plain;
         d2_q <= d1_q;
         if (!hold && jk_hit) off_q <= hit_off;
      end
   end
endmodule

// File: rtl/rx_sym_framer.sv
module rx_sym_framer
   import rx_sym_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             locked,
   input  logic             jk_hit,
   input  logic [SYM_W-1:0] aligned,
   input  logic             link_fail,
   output logic [NIB_W-1:0] rxd,
   output logic             rx_dv,
   output logic             rx_er,
   output logic             busy
);
   frame_st_e st_q;
   logic      idle_q;
   sym_dec_t  dec;

   assign dec  = decode_sym(aligned);
   assign busy = (st_q != FS_HUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FS_HUNT;
         idle_q <= 1'b0;
         rxd    <= '0;
         rx_dv  <= 1'b0;
         rx_er  <= 1'b0;
      end else begin
         rxd   <= '0;
         rx_dv <= 1'b0;
         rx_er <= 1'b0;
         if (link_fail) begin
            st_q   <= FS_HUNT;
            idle_q <= 1'b0;
         end else begin
            case (st_q)
               FS_HUNT: begin
                  idle_q <= 1'b0;
                  if (locked && jk_hit) begin
                     st_q  <= FS_SSD2;
                     rxd   <= SSD_NIB;
                     rx_dv <= 1'b1;
                  end
               end
               FS_SSD2: begin
                  st_q  <= FS_BODY;
                  rxd   <= SSD_NIB;
                  rx_dv <= 1'b1;
               end
               FS_BODY: begin
                  case (dec.kind)
                     SK_DATA: begin
                        rxd    <= dec.nib;
                        rx_dv  <= 1'b1;
                        idle_q <= 1'b0;
                     end
                     SK_END: st_q <= FS_HUNT;
                     SK_IDLE: begin
                        if (idle_q) begin
                           st_q <= FS_HUNT;
                        end else begin
                           rx_dv  <= 1'b1;
                           rx_er  <= 1'b1;
                           idle_q <= 1'b1;
                        end
                     end
                     default: begin
                        rx_dv  <= 1'b1;
                        rx_er  <= 1'b1;
                        idle_q <= 1'b0;
                     end
                  endcase
               end
               default: st_q <= FS_HUNT;
            endcase
         end
      end
   end
endmodule

// File: rtl/rx_sym_decoder.sv
module rx_sym_decoder
   import rx_sym_pkg::*;
#(
   parameter int LFSR_W     = 11,
   parameter int LFSR_TAP   = 9,
   parameter int LOCK_IDLES = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SYM_W-1:0] sym_in,
   input  logic             cipher_bypass,
   input  logic             link_fail,
   output logic [NIB_W-1:0] rxd,
   output logic             rx_dv,
   output logic             rx_er,
   output logic             receiving,
   output logic             lock_ok
);
   if (LFSR_W <= SYM_W) begin : g_bad_width
      $error("LFSR_W must exceed the symbol width");
   end
   if (LFSR_TAP < 1 || LFSR_TAP >= LFSR_W) begin : g_bad_tap
      $error("LFSR_TAP must lie in 1..LFSR_W-1");
   end
   if (LOCK_IDLES < 2) begin : g_bad_lock
      $error("LOCK_IDLES must be at least 2");
   end

   logic [SYM_W-1:0] plain, aligned;
   logic             locked, jk_hit, busy;

   rx_sym_descram #(
      .LFSR_W    (LFSR_W),
      .LFSR_TAP  (LFSR_TAP),
      .LOCK_IDLES(LOCK_IDLES)
   ) u_descram (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym_in   (sym_in),
      .bypass   (cipher_bypass),
      .link_fail(link_fail),
      .plain    (plain),
      .locked   (locked)
   );

   rx_sym_aligner u_align (
      .clk    (clk),
      .rst_n  (rst_n),
      .plain  (plain),
      .hold   (busy),
      .jk_hit (jk_hit),
      .aligned(aligned)
   );

   rx_sym_framer u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .locked   (locked),
      .jk_hit   (jk_hit),
      .aligned  (aligned),
      .link_fail(link_fail),
      .rxd      (rxd),
      .rx_dv    (rx_dv),
      .rx_er    (rx_er),
      .busy     (busy)
   );

   assign receiving = busy;
   assign lock_ok   = locked;
endmodule

// File: rtl/rx_sym_decoder_chk.sv
module rx_sym_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       link_fail,
   input logic [3:0] rxd,
   input logic       rx_dv,
   input logic       rx_er,
   input logic       receiving,
   input logic       lock_ok
);
   p_unlocked_nostart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_ok |=> !$rose(rx_dv));

   p_ssd_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_dv) |-> (rxd == 4'h5));

   p_ssd_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_dv) && !link_fail) |=> (rx_dv && rxd == 4'h5));

   p_err_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_er |-> (rx_dv && rxd == 4'h0));

   p_linkfail_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      link_fail |=> (!rx_dv && !lock_ok));

   p_recv_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      receiving == rx_dv);
endmodule

bind rx_sym_decoder rx_sym_decoder_chk u_chk (.*);

// File: tb/rx_sym_decoder_bench.sv
`timescale 1ns/1ps
module rx_sym_decoder_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] sym_in = '0;
   logic       cipher_bypass = 1'b0;
   logic       link_fail = 1'b0;
   logic [3:0] rxd;
   logic       rx_dv, rx_er, receiving, lock_ok;

   int nchk = 0;
   int nerr = 0;
   int recv_bad = 0;
   bit done = 0;

   logic [10:0] tx_s = 11'h5A3;
   bit          bq[$];
   logic [4:0]  cap[64];
   logic [4:0]  expv[64];
   int          cap_n, exp_n;

   localparam logic [4:0] B_J = 5'b11000, B_K = 5'b10001, B_T = 5'b01101;
   localparam logic [4:0] B_R = 5'b00111, B_H = 5'b00100, B_I = 5'b11111;

   rx_sym_decoder u_rx_sym_decoder (
      .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .cipher_bypass(cipher_bypass),
      .link_fail(link_fail), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
      .receiving(receiving), .lock_ok(lock_ok)
   );

   always #2.5 clk = ~clk;

   function automatic logic [4:0] enc(input logic [3:0] n);
      case (n)
         4'h0: return 5'b11110;  4'h1: return 5'b01001;
         4'h2: return 5'b10100;  4'h3: return 5'b10101;
         4'h4: return 5'b01010;  4'h5: return 5'b01011;
         4'h6: return 5'b01110;  4'h7: return 5'b01111;
         4'h8: return 5'b10010;  4'h9: return 5'b10011;
         4'hA: return 5'b10110;  4'hB: return 5'b10111;
         4'hC: return 5'b11010;  4'hD: return 5'b11011;
         4'hE: return 5'b11100;  default: return 5'b11101;
      endcase
   endfunction

   task automatic chk(input bit ok, input string what, input int act, input int expd);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, expd);
      end
   endtask

   task automatic push_bit(input bit p, input bit scr);
      bit n;
      n = tx_s[10] ^ tx_s[8];
      tx_s = {tx_s[9:0], n};
      bq.push_back(scr ? (p ^ n) : p);
   endtask

   task automatic push_sym(input logic [4:0] p, input bit scr);
      for (int i = 4; i >= 0; i--) push_bit(p[i], scr);
   endtask

   task automatic add_exp(input bit er, input logic [3:0] n);
      expv[exp_n] = {er, n};
      exp_n++;
   endtask

   // one symbol slot: sample outputs, then drive the next group
   task automatic step(input logic [4:0] s);
      @(negedge clk);
      if (rx_dv) begin
         if (cap_n < 64) cap[cap_n] = {rx_er, rxd};
         cap_n++;
         if (receiving !== 1'b1) recv_bad++;
      end else if (receiving !== 1'b0) recv_bad++;
      sym_in = s;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      link_fail = 1'b0;
      sym_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // kind: 0 normal, 1 H at pos, 2 code 00000 at pos, 3 idle abort,
   //       4 J then data (no start), 5 link fail after pos data nibbles
   task automatic run_frame(input bit scr, input int slip, input int len,
                            input int kind, input int pos, input string tag);
      bit lf_wait;
      int first_bad;
      logic [3:0] nb;
      do_reset();
      cipher_bypass = !scr;
      bq.delete();
      exp_n = 0;
      cap_n = 0;
      for (int i = 0; i < 24; i++) push_sym(B_I, scr);
      for (int i = 0; i < slip; i++) push_bit(1'b1, scr);
      if (kind == 4) begin
         push_sym(B_J, scr);
         push_sym(enc(4'h0), scr);
         push_sym(B_T, scr);
         push_sym(B_R, scr);
      end else begin
         push_sym(B_J, scr);
         push_sym(B_K, scr);
         add_exp(1'b0, 4'h5);
         add_exp(1'b0, 4'h5);
         for (int i = 0; i < len; i++) begin
            nb = 4'((i + slip * 3 + (scr ? 7 : 0)) & 15);
            if (kind == 1 && i == pos) begin
               push_sym(B_H, scr);
               add_exp(1'b1, 4'h0);
            end else if (kind == 2 && i == pos) begin
               push_sym(5'b00000, scr);
               add_exp(1'b1, 4'h0);
            end else begin
               push_sym(enc(nb), scr);
               add_exp(1'b0, nb);
            end
         end
         if (kind == 3) begin
            push_sym(B_I, scr);
            push_sym(B_I, scr);
            add_exp(1'b1, 4'h0);
         end else begin
            push_sym(B_T, scr);
            push_sym(B_R, scr);
         end
         if (kind == 5) exp_n = 2 + pos;
      end
      for (int i = 0; i < 16; i++) push_sym(B_I, scr);

      lf_wait = 0;
      while (bq.size() >= 5) begin
         logic [4:0] g;
         for (int i = 4; i >= 0; i--) g[i] = bq.pop_front();
         step(g);
         if (lf_wait) begin
            chk(rx_dv == 1'b0, {tag, " R9 rx_dv after link_fail"}, int'(rx_dv), 0);
            chk(lock_ok == 1'b0, {tag, " R9 lock_ok after link_fail"}, int'(lock_ok), 0);
            link_fail = 1'b0;
            lf_wait = 0;
         end else if (kind == 5 && cap_n == 2 + pos && link_fail == 1'b0 && rx_dv) begin
            link_fail = 1'b1;
            lf_wait = 1;
         end
      end
      repeat (4) step(B_I);

      chk(cap_n == exp_n, {tag, " frame nibble count (R7 R8)"}, cap_n, exp_n);
      first_bad = -1;
      for (int i = 0; i < exp_n && i < cap_n; i++)
         if (first_bad < 0 && cap[i] !== expv[i]) first_bad = i;
      chk(first_bad < 0, {tag, " frame content {er,nibble} (R3 R4 R5 R6)"},
          (first_bad < 0) ? 0 : int'(cap[first_bad]),
          (first_bad < 0) ? 0 : int'(expv[first_bad]));
   endtask

   initial begin
      #(5ns * 200000);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R12: reset state
      chk(rxd == 4'h0, "R12 rxd at reset", int'(rxd), 0);
      chk(rx_dv == 1'b0, "R12 rx_dv at reset", int'(rx_dv), 0);
      chk(rx_er == 1'b0, "R12 rx_er at reset", int'(rx_er), 0);
      chk(receiving == 1'b0, "R12 receiving at reset", int'(receiving), 0);
      chk(lock_ok == 1'b0, "R12 lock_ok at reset", int'(lock_ok), 0);

      // R1: twelve idles are one short of lock, thirteen reach it
      cipher_bypass = 1'b1;
      cap_n = 0;
      for (int i = 0; i < 12; i++) step(B_I);
      for (int i = 0; i < 4; i++) step(5'b00000);
      chk(lock_ok == 1'b0, "R1 no lock after 12 idles", int'(lock_ok), 0);
      for (int i = 0; i < 13; i++) step(B_I);
      for (int i = 0; i < 4; i++) step(5'b00000);
      chk(lock_ok == 1'b1, "R1 lock after 13 idles", int'(lock_ok), 1);

      // R2 R3 R4 R5 R7: both cipher settings against every bit slip
      for (int scr = 0; scr < 2; scr++)
         for (int slip = 0; slip < 5; slip++)
            run_frame(scr[0], slip, 16, 0, 0,
                      $sformatf("sweep scr=%0d slip=%0d", scr, slip));

      // R6: H symbol and an unused code inside frames
      run_frame(1'b1, 2, 8, 1, 3, "R6 H symbol");
      run_frame(1'b0, 4, 8, 2, 5, "R6 unused code");
      // R8: two idles before T
      run_frame(1'b1, 3, 6, 3, 0, "R8 idle abort");
      run_frame(1'b0, 1, 6, 3, 0, "R8 idle abort bypass");
      // R9: link failure mid-frame
      run_frame(1'b1, 1, 10, 5, 4, "R9 link fail");
      // R10: J followed by data is not a start
      run_frame(1'b1, 4, 0, 4, 0, "R10 false start");
      run_frame(1'b0, 0, 0, 4, 0, "R10 false start bypass");

      // R11: receiving matched rx_dv in every sampled slot
      chk(recv_bad == 0, "R11 receiving vs rx_dv mismatches", recv_bad, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule